// File: doc/BRIEF.md
# Inactive-Engine CPI Estimator

This block sits beside a core that carries two execution engines sharing one front end, only one of which runs at a time. While one engine runs, the block counts that engine's micro-architectural events over a quantum. When the quantum closes, it predicts the cycles-per-instruction figure that the idle engine would have reached on the same stretch of code. A switching controller compares that prediction with the running engine's own figure and decides which engine to use for the next quantum.

The prediction is a signed linear model. Each counted event has its own weight. The running cycle count also has a weight, and a bias term is added. Two independent weight sets exist: one predicts the big engine while the little engine runs, and the other predicts the little engine while the big engine runs. The weights come out of reset holding design-time defaults and can be reloaded per application. The sum is formed serially, one multiply-accumulate per clock. The result is clamped to a legal range and presented with a one-cycle valid strobe.

Top module: `est_inactive_cpi`

## Requirements
- R1: During and right after reset, `busy` and `est_valid` are 0 and `est_cpi` is 0.
- R2: Only the event vector of the running engine is counted: `ev_big` when `active_big`=1, `ev_little` when `active_big`=0. Bit 0 is an L2 miss, bit 1 an L2 hit, bit 2 a branch mispredict, bit 3 a parallel-issue (ILP) event and bit 4 an overlapped-miss (MLP) event. Each set bit adds one to its counter on that clock.
- R3: Term 5 counts every clock since the previous capture, including the capture clock itself. Term 6 is a bias whose weight is added at output scale, because its count is fixed at 256.
- R4: The result is floor((sum over terms 0..5 of count×weight + weight6×256) / 256). Weights are 16-bit two's complement with 8 fraction bits.
- R5: `active_big`, sampled on the capture clock, picks the weight set (1 selects set 1, 0 selects set 0). `est_dir` reports that choice alongside the result.
- R6: A capture happens on a clock where `quantum_end`=1 and `busy`=0. `busy` is 1 from the next cycle until the result appears. `est_valid` is a single-cycle pulse that becomes visible exactly 7 clocks after the capture clock.
- R7: A capture clears every counter. Events present on the capture clock belong to the quantum being closed.
- R8: `quantum_end` while `busy`=1 is ignored. No extra result is produced, and counting continues uninterrupted.
- R9: A negative result reads as 0, and a result above 3000 reads as 3000.
- R10: Each counter holds at 65535 instead of wrapping.
- R11: With `wt_we`=1 and `busy`=0, `wt_val` is written into set `wt_dir`, term `wt_sel` (0..6). Writes made while busy, or with `wt_sel`=7, change nothing.
- R12: The reset weights, as raw values for terms 0..6, are set 0: 512, 64, 128, -32, -64, 128, 10 and set 1: 384, 32, 64, 96, 32, 320, 4.
- R13: `est_cpi` keeps its value between result strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_big | input | 1 | 1 when the big engine is the one running |
| ev_big | input | 5 | Event increments from the big engine |
| ev_little | input | 5 | Event increments from the little engine |
| quantum_end | input | 1 | Closes the current quantum |
| wt_we | input | 1 | Weight write enable |
| wt_dir | input | 1 | Weight set to write |
| wt_sel | input | 3 | Term index to write |
| wt_val | input | 16 | Signed weight value, 8 fraction bits |
| busy | output | 1 | Multiply-accumulate in progress |
| est_valid | output | 1 | One-cycle strobe for a new estimate |
| est_dir | output | 1 | Weight set used for the current estimate |
| est_cpi | output | 12 | Clamped estimate |

## Verification
The bench aims at the capture clock. A design that dropped the boundary clock's events or its cycle count, or failed to clear the counters, would be off by a few counts in the next quantum. It also presents toggling events on the idle engine's vector: a wrong select would fold them into the sum. A second `quantum_end` during the busy window, and weight writes during that window or to index 7, are issued so that a restart, a corrupted weight or a spurious strobe shows up as a wrong value or a result out of sequence. A quantum longer than 65535 cycles, combined with weights for both clamps, exposes counters that wrap and results that escape the 0..3000 range.

// File: rtl/est_pkg.sv
package est_pkg;
  localparam int N_EV    = 5;
  localparam int N_TERMS = N_EV + 2;
  localparam int SEL_W   = $clog2(N_TERMS);
  localparam int CNT_W   = 16;
  localparam int WT_W    = 16;
  localparam int FRAC    = 8;
  localparam int CPI_W   = 12;
  localparam int CPI_MAX = 3000;
  localparam int ACC_W   = CNT_W + WT_W + $clog2(N_TERMS) + 2;

  typedef logic [CNT_W-1:0]        cnt_t;
  typedef logic signed [WT_W-1:0]  wt_t;
  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [CPI_W-1:0]        cpi_t;
  typedef enum logic {ST_IDLE, ST_MAC} st_t;

  // design-time weight table; set 0 predicts big from little, set 1 the reverse
  function automatic wt_t default_weight(input logic dir, input int idx);
    wt_t w;
    w = '0;
    if (!dir) begin
      case (idx)
        0: w = 16'sd512;  1: w = 16'sd64;  2: w = 16'sd128;
        3: w = -16'sd32;  4: w = -16'sd64; 5: w = 16'sd128;
        6: w = 16'sd10;   default: w = '0;
      endcase
    end else begin
      case (idx)
        0: w = 16'sd384;  1: w = 16'sd32;  2: w = 16'sd64;
        3: w = 16'sd96;   4: w = 16'sd32;  5: w = 16'sd320;
        6: w = 16'sd4;    default: w = '0;
      endcase
    end
    return w;
  endfunction

  function automatic cnt_t sat_inc(input cnt_t c, input logic inc);
    return (inc && (c != '1)) ? c + cnt_t'(1) : c;
  endfunction

  function automatic acc_t term_product(input cnt_t c, input wt_t w);
    acc_t a;
    acc_t b;
    a = acc_t'({1'b0, c});
    b = acc_t'(w);
    return a * b;
  endfunction

  function automatic cpi_t sat_cpi(input acc_t s);
    acc_t sh;
    sh = s >>> FRAC;
    if (sh < 0) return '0;
    if (sh > acc_t'(CPI_MAX)) return cpi_t'(CPI_MAX);
    return cpi_t'(sh);
  endfunction
endpackage

// File: rtl/est_counters.sv
module est_counters
  import est_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EV-1:0]   ev,
  input  logic              clr,
  output cnt_t [N_EV:0]     cnt,
  output cnt_t [N_EV:0]     cnt_nxt
);
  for (genvar i = 0; i < N_EV; i++) begin : g_ev
    assign cnt_nxt[i] = sat_inc(cnt[i], ev[i]);
  end
  assign cnt_nxt[N_EV] = sat_inc(cnt[N_EV], 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt_nxt;
  end
endmodule

// File: rtl/est_weights.sv
module est_weights
  import est_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_dir,
  input  logic [SEL_W-1:0] wr_sel,
  input  wt_t              wr_val,
  input  logic             rd_dir,
  input  logic [SEL_W-1:0] rd_sel,
  output wt_t              rd_val
);
  wt_t w_q [2][N_TERMS];

  always_ff @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      for (int t = 0; t < N_TERMS; t++) begin
        if (!rst_n)
          w_q[d][t] <= default_weight(d[0], t);
        else if (wr_en && (wr_dir == d[0]) && (wr_sel == SEL_W'(t)))
          w_q[d][t] <= wr_val;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int t = 0; t < N_TERMS; t++)
      if (rd_sel == SEL_W'(t)) rd_val = w_q[rd_dir][t];
  end
endmodule

// File: rtl/est_mac.sv
module est_mac
  import est_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  cnt_t [N_TERMS-1:0]   terms,
  input  wt_t                  weight,
  output logic [SEL_W-1:0]     sel,
  output logic                 busy,
  output logic                 last,
  output logic                 done,
  output cpi_t                 result
);
  st_t                state;
  cnt_t [N_TERMS-1:0] snap_q;
  acc_t               acc;
  acc_t               sum;

  assign busy = (state == ST_MAC);
  assign last = busy && (sel == SEL_W'(N_TERMS - 1));
  assign sum  = acc + term_product(snap_q[sel], weight);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sel    <= '0;
      acc    <= '0;
      snap_q <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          snap_q <= terms;
          acc    <= '0;
          sel    <= '0;
          state  <= ST_MAC;
        end
        ST_MAC: begin
          acc <= sum;
          if (last) begin
            result <= sat_cpi(sum);
            done   <= 1'b1;
            sel    <= '0;
            state  <= ST_IDLE;
          end else begin
            sel <= sel + SEL_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/est_inactive_cpi.sv
module est_inactive_cpi
  import est_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_big,
  input  logic [N_EV-1:0]  ev_big,
  input  logic [N_EV-1:0]  ev_little,
  input  logic             quantum_end,
  input  logic             wt_we,
  input  logic             wt_dir,
  input  logic [SEL_W-1:0] wt_sel,
  input  logic [WT_W-1:0]  wt_val,
  output logic             busy,
  output logic             est_valid,
  output logic             est_dir,
  output logic [CPI_W-1:0] est_cpi
);
  logic [N_EV-1:0]    ev_act;
  logic               cap_fire;
  logic               mac_last;
  logic               dir_q;
  logic [SEL_W-1:0]   mac_sel;
  wt_t                w_cur;
  cnt_t [N_EV:0]      cnt_now;
  cnt_t [N_EV:0]      cnt_nxt;
  cnt_t [N_TERMS-1:0] snap;
  cnt_t               cyc_cnt;

  assign ev_act   = active_big ? ev_big : ev_little;
  assign cap_fire = quantum_end & ~busy;
  assign snap     = {cnt_t'(cnt_t'(1) << FRAC), cnt_nxt};
  assign cyc_cnt  = cnt_now[N_EV];
  assign est_dir  = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        dir_q <= 1'b0;
    else if (cap_fire) dir_q <= active_big;
  end

  est_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .ev(ev_act), .clr(cap_fire),
    .cnt(cnt_now), .cnt_nxt(cnt_nxt)
  );

  est_weights u_wt (
    .clk(clk), .rst_n(rst_n), .wr_en(wt_we & ~busy), .wr_dir(wt_dir),
    .wr_sel(wt_sel), .wr_val(wt_t'(wt_val)), .rd_dir(dir_q),
    .rd_sel(mac_sel), .rd_val(w_cur)
  );

  est_mac u_mac (
    .clk(clk), .rst_n(rst_n), .start(cap_fire), .terms(snap),
    .weight(w_cur), .sel(mac_sel), .busy(busy), .last(mac_last),
    .done(est_valid), .result(est_cpi)
  );
endmodule

// File: rtl/est_chk.sv
module est_chk
  import est_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             quantum_end,
  input logic             busy,
  input logic             est_valid,
  input logic [CPI_W-1:0] est_cpi,
  input logic             cap_fire,
  input logic             mac_last,
  input logic [CNT_W-1:0] cyc_cnt
);
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |=> !est_valid);
  // R6
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> $past(busy));
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(quantum_end));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mac_last) |=> (busy && !est_valid));
  // R7
  clear_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (cyc_cnt == '0));
  // R9
  cpi_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_cpi <= CPI_W'(CPI_MAX));
  // R13
  cpi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !est_valid |-> $stable(est_cpi));
endmodule

bind est_inactive_cpi est_chk u_chk (
  .clk(clk), .rst_n(rst_n), .quantum_end(quantum_end), .busy(busy),
  .est_valid(est_valid), .est_cpi(est_cpi), .cap_fire(cap_fire),
  .mac_last(mac_last), .cyc_cnt(cyc_cnt)
);

// File: tb/sim_est_inactive_cpi.sv
`timescale 1ns/1ps
module sim_est_inactive_cpi;
  import est_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic active_big = 1'b0;
  logic [N_EV-1:0] ev_big = '0, ev_little = '0;
  logic quantum_end = 1'b0, wt_we = 1'b0, wt_dir = 1'b0;
  logic [SEL_W-1:0] wt_sel = '0;
  logic [WT_W-1:0] wt_val = '0;
  logic busy, est_valid, est_dir;
  logic [CPI_W-1:0] est_cpi;

  always #5 clk = ~clk;

  est_inactive_cpi u0 (
    .clk(clk), .rst_n(rst_n), .active_big(active_big), .ev_big(ev_big),
    .ev_little(ev_little), .quantum_end(quantum_end), .wt_we(wt_we),
    .wt_dir(wt_dir), .wt_sel(wt_sel), .wt_val(wt_val), .busy(busy),
    .est_valid(est_valid), .est_dir(est_dir), .est_cpi(est_cpi)
  );

  typedef struct { longint cpi; bit dir; int edge_no; string tag; } exp_t;
  exp_t sb[$];
  int nchk = 0, nfail = 0, cyc = 0, busy_left = 0;
  longint mcnt [N_EV+1];
  longint mw [2][N_TERMS];
  longint last_cpi = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint model_cpi(input bit d);
    longint s = 0;
    longint r;
    for (int i = 0; i <= N_EV; i++) s += mcnt[i] * mw[d][i];
    s += mw[d][N_TERMS-1] * 256;
    r = s >>> 8;
    if (r < 0) r = 0;
    if (r > 3000) r = 3000;
    return r;
  endfunction

  // driver: called at a negedge, drives one clock, returns at the next negedge
  task automatic step(input logic ab, input logic [N_EV-1:0] eb, input logic [N_EV-1:0] el,
                      input logic qe, input logic we, input logic wd,
                      input logic [SEL_W-1:0] ws, input longint wv, input string tag);
    bit is_busy;
    logic [N_EV-1:0] ev;
    exp_t e;
    if (busy_left == N_TERMS)
      check(busy == 1'b1, "R6", "busy after capture", busy, 1);
    active_big = ab; ev_big = eb; ev_little = el; quantum_end = qe;
    wt_we = we; wt_dir = wd; wt_sel = ws; wt_val = wv[WT_W-1:0];
    is_busy = (busy_left > 0);
    if (busy_left > 0) busy_left--;
    ev = ab ? eb : el;
    for (int i = 0; i < N_EV; i++) if (ev[i] && mcnt[i] < 65535) mcnt[i]++;
    if (mcnt[N_EV] < 65535) mcnt[N_EV]++;
    if (we && !is_busy && ws < N_TERMS) mw[wd][ws] = longint'($signed(wv[WT_W-1:0]));
    if (qe && !is_busy) begin
      e.cpi = model_cpi(ab); e.dir = ab; e.edge_no = cyc + 1 + N_TERMS; e.tag = tag;
      sb.push_back(e);
      for (int i = 0; i <= N_EV; i++) mcnt[i] = 0;
      busy_left = N_TERMS;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic ab);
    for (int i = 0; i < n; i++) step(ab, '0, '0, 0, 0, 0, '0, 0, "idle");
  endtask

  task automatic wr(input logic ab, input logic d, input int s, input longint v);
    step(ab, '0, '0, 0, 1, d, SEL_W'(s), v, "wr");
  endtask

  task automatic quantum(input logic ab, input int len, input int seed, input string tag);
    for (int i = 0; i < len; i++) begin
      logic [N_EV-1:0] p;
      p = N_EV'((i * 7 + seed) ^ (i >> 1));
      step(ab, ab ? p : ~p, ab ? ~p : p, (i == len - 1), 0, 0, '0, 0, tag);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (est_valid) begin
        if (sb.size() == 0) begin
          check(0, "R8", "unexpected result strobe", est_cpi, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(est_cpi == e.cpi, e.tag, "estimate", est_cpi, e.cpi);
          check(est_dir == e.dir, {e.tag, " R5"}, "direction", est_dir, e.dir);
          check(cyc == e.edge_no, "R6", "result latency edge", cyc, e.edge_no);
        end
        last_cpi = est_cpi;
      end else if (est_cpi != last_cpi) begin
        check(0, "R13", "estimate changed without strobe", est_cpi, last_cpi);
      end
    end
  end

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    // R12 defaults restated
    mw[0] = '{512, 64, 128, -32, -64, 128, 10};
    mw[1] = '{384, 32, 64, 96, 32, 320, 4};
    for (int i = 0; i <= N_EV; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R1", "busy in reset", busy, 0);
    check(est_valid == 0, "R1", "valid in reset", est_valid, 0);
    check(est_cpi == 0, "R1", "estimate in reset", est_cpi, 0);
    rst_n = 1'b1;
    idle(1, 0);
    check(busy == 0 && est_valid == 0, "R1", "idle after reset", busy, 0);
    // R2 R3 R4 R12: little running, defaults, big vector toggling
    quantum(0, 20, 3, "R2 R3 R4 R12");
    idle(9, 0);
    // R5 R7: big running, counters restart from the capture
    quantum(1, 30, 11, "R5 R7");
    idle(9, 1);
    // R8: second quantum_end during busy is ignored
    quantum(0, 12, 5, "R8 first");
    step(0, 5'b00011, 5'b00101, 0, 0, 0, '0, 0, "R8");
    step(0, 5'b00011, 5'b00101, 0, 0, 0, '0, 0, "R8");
    step(0, 5'b00011, 5'b01101, 1, 0, 0, '0, 0, "R8 ignored");
    quantum(0, 10, 9, "R8 continued");
    idle(9, 0);
    // R11: writes while idle, index 7 ignored, write while busy ignored
    wr(0, 0, 0, 300); wr(0, 0, 3, -200); wr(0, 0, 6, 55); wr(0, 0, 7, 9999);
    quantum(0, 15, 2, "R11 loaded");
    wr(0, 0, 6, 2000); wr(0, 0, 1, -500);
    idle(8, 0);
    quantum(0, 15, 4, "R11 busy write ignored");
    idle(9, 0);
    // R9 low clamp
    wr(1, 1, 6, -3000);
    quantum(1, 10, 1, "R9 low clamp");
    idle(9, 1);
    // R10: counter hold at 65535
    wr(0, 0, 0, 8);
    for (int t = 1; t < N_TERMS; t++) wr(0, 0, t, 0);
    for (int i = 0; i < 65999; i++) step(0, '0, 5'b11111, 0, 0, 0, '0, 0, "R10");
    step(0, '0, 5'b11111, 1, 0, 0, '0, 0, "R10 hold");
    idle(9, 0);
    // R9 high clamp
    wr(0, 0, 6, 5000);
    quantum(0, 10, 6, "R9 high clamp");
    idle(12, 0);
    check(sb.size() == 0, "R6", "results outstanding", sb.size(), 0);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule